// File: doc/BRIEF.md
# Indicator LED and Stop-Line Controller

This block drives the indicator pins of a playback engine: two LED pins and a set of five static stop lines. The sequencer's load instructions reach it through a small write port that selects one of three registers. Two of these are mode registers. They choose between steady and flashing LEDs, choose whether the two LEDs blink together or take turns, and route two shared pins. One shared pin carries either the second LED or stop line C. The other carries either stop line A or a busy indication taken from the playback-active flag.

The flash waveform comes from a divider that counts pulses on a clock-enable input. It does not count raw clock cycles. The number of pulses per half period is a parameter, sized so that the full blink comes out at about 3 Hz for the chosen enable rate. The LEDs light only while playback is active. Whenever flashing is switched off, the flash phase is cleared, so each new flash run starts with LED1 lit.

Top module: `led_stop_ctrl`

## Requirements
- R1: After reset, both mode registers hold all ones and the stop register holds ones in all five bits. With playback idle, this gives: both LEDs dark, the shared LED2/stop-C pin routed to LED2, and stop lines A, B, D and E high.
- R2: A write with `wr_en` high at a clock edge updates the register selected by `wr_sel`: 0 selects mode register 0, 1 selects mode register 1, 2 selects the stop register. Code 3 changes nothing. The new value shows on the pins from that edge onward.
- R3: Stop register bits 0 to 4 drive stop lines A to E in that order. A bit value of 1 drives its line high. Write-data bits 7 to 5 are discarded for this register.
- R4: Mode register 0 bit 6 routes the shared pin `led2_or_stopc_o`. A value of 1 puts LED2 on the pin and 0 puts stop line C on it.
- R5: Mode register 0 bit 2 routes the shared pin `stopa_or_busy_o`. A value of 1 puts stop line A on the pin. A value of 0 puts the busy indication on it, which is high exactly while `playing` is high.
- R6: While `playing` is low, LED1 and LED2 are both dark, whatever the mode.
- R7: With mode register 0 bit 7 at 0 (steady mode), LED1 and LED2 are lit for as long as `playing` is high.
- R8: With mode register 0 bit 7 at 1 (flash mode), the flash phase flips after every HALF_TICKS pulses of `flash_tick`. LED1 is lit during the first half period after flashing is enabled, dark during the next, and so on.
- R9: In flash mode, mode register 1 bit 5 at 0 makes LED2 follow LED1 exactly. At 1 it makes LED2 the complement of LED1 while playing. A change of this bit leaves the running phase untouched.
- R10: While flash mode is off, the phase is held cleared and `flash_tick` pulses have no effect. Re-enabling flash mode restarts the waveform with LED1 lit, even if it was stopped in the dark half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode0, 1 mode1, 2 stop, 3 none |
| wr_data | input | 8 | Write data |
| playing | input | 1 | Playback-active flag |
| flash_tick | input | 1 | Clock enable for the flash timebase |
| led1_o | output | 1 | LED1 drive |
| led2_or_stopc_o | output | 1 | LED2 or stop line C |
| stopa_or_busy_o | output | 1 | Stop line A or busy |
| stopb_o | output | 1 | Stop line B |
| stopd_o | output | 1 | Stop line D |
| stope_o | output | 1 | Stop line E |

## Verification
The bench sweeps all 32 stop-register values under both routings of the shared pins, and toggles `playing` along the way. A swapped stop bit or an inverted route selection therefore shows up as a wrong level on some pin. Flash runs are checked tick by tick against a phase computed from the tick count. This catches an off-by-one divider, which would flip one tick early or late. An alternate/synchronous swap shows up as LED2 matching LED1 when it should oppose it, or the reverse. The bench stops a flash run in the dark half and re-enables it. A design that failed to clear the phase would resume with LED1 dark. A write with the unused select code must leave every pin unchanged.

// File: rtl/ind_pkg.sv
package ind_pkg;

  typedef enum logic [1:0] {
    SEL_MODE0 = 2'd0,
    SEL_MODE1 = 2'd1,
    SEL_STOP  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int NUM_STOP    = 5;
  localparam int M0_FLASH    = 7;
  localparam int M0_LED2PIN  = 6;
  localparam int M0_STOPAPIN = 2;
  localparam int M1_ALT      = 5;

  localparam logic [7:0]          MODE_RESET = 8'hFF;
  localparam logic [NUM_STOP-1:0] STOP_RESET = '1;

  typedef struct packed {
    logic [7:0]          mode0;
    logic [7:0]          mode1;
    logic [NUM_STOP-1:0] stop;
  } ind_regs_t;

  // LED level: dark when idle, lit when steady, else lit on the matching phase.
  function automatic logic led_level(input logic playing, input logic flash,
                                     input logic phase, input logic lit_phase);
    return playing & (~flash | (phase == lit_phase));
  endfunction

  // Shared-pin selection: primary source when sel is set, else alternate.
  function automatic logic pin_route(input logic sel, input logic primary,
                                     input logic alternate);
    return sel ? primary : alternate;
  endfunction

endpackage

// File: rtl/ind_regfile.sv
module ind_regfile
  import ind_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output ind_regs_t  regs_o
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[7:NUM_STOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_o.mode0 <= MODE_RESET;
      regs_o.mode1 <= MODE_RESET;
      regs_o.stop  <= STOP_RESET;
    end else if (wr_en) begin
      case (sel)
        SEL_MODE0: regs_o.mode0 <= wr_data;
        SEL_MODE1: regs_o.mode1 <= wr_data;
        SEL_STOP:  regs_o.stop  <= wr_data[NUM_STOP-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/ind_flash_timer.sv
module ind_flash_timer #(
  parameter int HALF_TICKS = 167
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic phase_o,
  output logic toggle_o
);

  localparam int              CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign toggle_o = enable & tick & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (!enable) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= toggle_o ? '0 : cnt_q + 1'b1;
      if (toggle_o) phase_o <= ~phase_o;
    end
  end

endmodule

// File: rtl/ind_pin_mux.sv
module ind_pin_mux
  import ind_pkg::*;
(
  input  ind_regs_t            regs_i,
  input  logic                 playing,
  input  logic                 phase,
  output logic                 led1_raw,
  output logic                 led2_raw,
  output logic                 led2_pin,
  output logic                 stopa_pin,
  output logic [NUM_STOP-1:0]  stop_lines
);

  logic unused_mode_bits;
  assign unused_mode_bits = ^{regs_i.mode0, regs_i.mode1};

  for (genvar i = 0; i < NUM_STOP; i++) begin : g_stop
    assign stop_lines[i] = regs_i.stop[i];
  end

  assign led1_raw  = led_level(playing, regs_i.mode0[M0_FLASH], phase, 1'b0);
  assign led2_raw  = led_level(playing, regs_i.mode0[M0_FLASH], phase,
                               regs_i.mode1[M1_ALT]);
  assign led2_pin  = pin_route(regs_i.mode0[M0_LED2PIN], led2_raw, stop_lines[2]);
  assign stopa_pin = pin_route(regs_i.mode0[M0_STOPAPIN], stop_lines[0], playing);

endmodule

// File: rtl/led_stop_ctrl.sv
module led_stop_ctrl
  import ind_pkg::*;
#(
  parameter int HALF_TICKS = 167
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       playing,
  input  logic       flash_tick,
  output logic       led1_o,
  output logic       led2_or_stopc_o,
  output logic       stopa_or_busy_o,
  output logic       stopb_o,
  output logic       stopd_o,
  output logic       stope_o
);

  ind_regs_t           regs;
  logic                flash_en;
  logic                flash_phase;
  logic                flash_toggle;
  logic                led1_raw;
  logic                led2_raw;
  logic                m0_led2pin;
  logic                m0_stopapin;
  logic                m1_alt;
  logic [NUM_STOP-1:0] stop_lines;

  assign flash_en    = regs.mode0[M0_FLASH];
  assign m0_led2pin  = regs.mode0[M0_LED2PIN];
  assign m0_stopapin = regs.mode0[M0_STOPAPIN];
  assign m1_alt      = regs.mode1[M1_ALT];

  ind_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  ind_flash_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (flash_en),
    .tick     (flash_tick),
    .phase_o  (flash_phase),
    .toggle_o (flash_toggle)
  );

  ind_pin_mux u_mux (
    .regs_i     (regs),
    .playing    (playing),
    .phase      (flash_phase),
    .led1_raw   (led1_raw),
    .led2_raw   (led2_raw),
    .led2_pin   (led2_or_stopc_o),
    .stopa_pin  (stopa_or_busy_o),
    .stop_lines (stop_lines)
  );

  assign led1_o  = led1_raw;
  assign stopb_o = stop_lines[1];
  assign stopd_o = stop_lines[3];
  assign stope_o = stop_lines[4];

endmodule

// File: rtl/led_stop_ctrl_chk.sv
module led_stop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       playing,
  input logic       flash_en,
  input logic       flash_phase,
  input logic       flash_toggle,
  input logic       m0_led2pin,
  input logic       m0_stopapin,
  input logic       m1_alt,
  input logic       led1_o,
  input logic       led2_pin,
  input logic       stopa_pin,
  input logic       stopb_o,
  input logic       stopd_o,
  input logic       stope_o
);

  logic unused_chk;
  assign unused_chk = ^{wr_data[7:5], wr_data[2], wr_data[0]};

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !playing |-> (!led1_o && !(m0_led2pin && led2_pin))); // R6

  AST_STEADY_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && !flash_en) |-> (led1_o && (!m0_led2pin || led2_pin))); // R7

  AST_ALT_OPPOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && flash_en && m1_alt && m0_led2pin) |-> (led1_o != led2_pin)); // R9

  AST_SYNC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && flash_en && !m1_alt && m0_led2pin) |-> (led1_o == led2_pin)); // R9

  AST_BUSY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !m0_stopapin |-> (stopa_pin == playing)); // R5

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_en |=> !flash_phase); // R10

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    flash_toggle |=> (flash_phase != $past(flash_phase))); // R8

  AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=>
      ({stope_o, stopd_o, stopb_o} == {$past(wr_data[4]), $past(wr_data[3]), $past(wr_data[1])})); // R3

endmodule

bind led_stop_ctrl led_stop_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .playing      (playing),
  .flash_en     (flash_en),
  .flash_phase  (flash_phase),
  .flash_toggle (flash_toggle),
  .m0_led2pin   (m0_led2pin),
  .m0_stopapin  (m0_stopapin),
  .m1_alt       (m1_alt),
  .led1_o       (led1_o),
  .led2_pin     (led2_or_stopc_o),
  .stopa_pin    (stopa_or_busy_o),
  .stopb_o      (stopb_o),
  .stopd_o      (stopd_o),
  .stope_o      (stope_o)
);

// File: tb/led_stop_ctrl_tb.sv
`timescale 1ns/1ps
module led_stop_ctrl_tb;

  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       playing = 1'b0;
  logic       flash_tick = 1'b0;
  logic       led1_o, led2_or_stopc_o, stopa_or_busy_o, stopb_o, stopd_o, stope_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int ticks = 0;

  always #2.5 clk = ~clk;

  led_stop_ctrl #(.HALF_TICKS(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .playing(playing), .flash_tick(flash_tick), .led1_o(led1_o),
    .led2_or_stopc_o(led2_or_stopc_o), .stopa_or_busy_o(stopa_or_busy_o),
    .stopb_o(stopb_o), .stopd_o(stopd_o), .stope_o(stope_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic set_play(input logic v);
    @(negedge clk);
    playing = v;
    #1;
  endtask

  task automatic tick1();
    @(negedge clk);
    flash_tick = 1'b1;
    @(negedge clk);
    flash_tick = 1'b0;
    #1;
    ticks++;
  endtask

  function automatic logic exp_led1(input int n);
    return ((n / H) % 2) == 0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset defaults, idle
    check("R1 led1", led1_o, 1'b0);
    check("R1 led2 pin", led2_or_stopc_o, 1'b0);
    check("R1 stopA", stopa_or_busy_o, 1'b1);
    check("R1 stopB", stopb_o, 1'b1);
    check("R1 stopD", stopd_o, 1'b1);
    check("R1 stopE", stope_o, 1'b1);
    // R1 defaults select flash, alternate: LED1 lit first, LED2 dark
    set_play(1'b1);
    check("R1 led1 play", led1_o, 1'b1);
    check("R1 led2 play", led2_or_stopc_o, 1'b0);

    // R3 R4 R5 sweep with shared pins on stop C and busy
    wr(2'd0, 8'h00);
    for (int v = 0; v < 32; v++) begin
      wr(2'd2, 8'hE0 | 8'(v));
      set_play(v[0] ^ v[3]);
      check("R3 stopB", stopb_o, v[1]);
      check("R3 stopD", stopd_o, v[3]);
      check("R3 stopE", stope_o, v[4]);
      check("R4 stopC pin", led2_or_stopc_o, v[2]);
      check("R5 busy", stopa_or_busy_o, v[0] ^ v[3]);
    end
    // R5 stop A route
    wr(2'd0, 8'h04);
    for (int v = 0; v < 32; v++) begin
      wr(2'd2, 8'(v));
      set_play(v[1]);
      check("R5 stopA pin", stopa_or_busy_o, v[0]);
      check("R4 stopC pin", led2_or_stopc_o, v[2]);
    end

    // R2 unused select code changes nothing
    wr(2'd2, 8'h15);
    wr(2'd3, 8'h0A);
    check("R2 stopA", stopa_or_busy_o, 1'b1);
    check("R2 stopB", stopb_o, 1'b0);
    check("R2 stopC", led2_or_stopc_o, 1'b1);
    check("R2 stopD", stopd_o, 1'b0);
    check("R2 stopE", stope_o, 1'b1);

    // R4 R7 R6 steady LEDs on LED2 pin
    wr(2'd0, 8'h44);
    set_play(1'b1);
    check("R7 led1", led1_o, 1'b1);
    check("R7 led2", led2_or_stopc_o, 1'b1);
    set_play(1'b0);
    check("R6 led1", led1_o, 1'b0);
    check("R6 led2 over stopC=1", led2_or_stopc_o, 1'b0);

    // R8 R9 synchronous flash
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hC4);
    ticks = 0;
    set_play(1'b1);
    for (int k = 0; k < 12; k++) begin
      check("R8 led1 sync", led1_o, exp_led1(ticks));
      check("R9 led2 sync", led2_or_stopc_o, exp_led1(ticks));
      tick1();
    end
    // R9 alternate, phase continues
    wr(2'd1, 8'h20);
    for (int k = 0; k < 9; k++) begin
      check("R8 led1 alt", led1_o, exp_led1(ticks));
      check("R9 led2 alt", led2_or_stopc_o, ~exp_led1(ticks));
      tick1();
    end
    check("R8 dark half", led1_o, 1'b0);
    set_play(1'b0);
    check("R6 flash led1", led1_o, 1'b0);
    check("R6 flash led2", led2_or_stopc_o, 1'b0);
    set_play(1'b1);

    // R10 restart and ticks ignored while off
    wr(2'd0, 8'h44);
    tick1();
    tick1();
    wr(2'd0, 8'hC4);
    ticks = 0;
    check("R10 restart led1", led1_o, 1'b1);
    check("R10 restart led2", led2_or_stopc_o, 1'b0);
    for (int k = 0; k < 7; k++) begin
      tick1();
      check("R10 rerun led1", led1_o, exp_led1(ticks));
    end

    finish_run();
  end

endmodule